// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block turns a parameterised group of external interrupt lines into vector delivery requests for one local interrupt controller. Each line owns a programmable 64-bit routing entry. The entry holds the vector to raise, a delivery mode, a destination mode, the line polarity, edge or level sensing, a mask bit and a destination identifier. Software never addresses an entry directly. It writes a register number into a byte-wide index register and then reads or writes that register through a 32-bit data window. A version register at a fixed index reports how many entries the table holds.

Unmasked lines raise requests. The polarity bit decides whether the line is active high or active low. The lowest-numbered line with a pending event is offered on the request port and stays there until the local controller accepts it. Edge entries raise one request per rising edge of the effective level. Level entries raise a request while the line is active. Once a level request is accepted, the entry sets its remote-IRR flag and raises nothing more until software writes the entry's vector to the end-of-interrupt port. If the line is still active at that point, it is offered again.

Top module: `irt_ctrl`

## Requirements
- R1: The bus has three targets chosen by `bus_sel`: 0 is the 8-bit index register, 1 is the data window and 2 is the end-of-interrupt port. Reading target 0 returns the index last written. Reading target 1 returns the register the index selects, and a write to target 1 updates that register on the next clock edge. A window read of an unused index returns zero.
- R2: The entry for line n has its low word at index 0x10+2n and its high word at index 0x11+2n. Low-word layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13] (1 = active low), remote IRR [14], trigger [15] (0 = edge, 1 = level), mask [16] (1 = disabled). Bits 31:17 read as zero. The high word carries the destination ID in bits 31:24, and its bits 23:0 read as zero. After reset every low word reads 0x0001_0000 and every high word reads 0.
- R3: The version register at index 0x01 reads 0x20 in bits 7:0 and the entry count in bits 23:16, with all other bits zero. Writes to it are ignored.
- R4: An entry with its mask bit set raises no request, whatever level its line holds.
- R5: On an unmasked edge entry, a rising edge of the effective line level makes `req_valid` high after the second clock edge. The request stays up until the first edge at which `req_ready` is high, and no further request follows while the line stays active.
- R6: On an unmasked level entry, an active line makes `req_valid` high after the first clock edge. When the request is accepted, remote IRR (bit 14) becomes 1 and the entry raises no further request.
- R7: A write of value v to the end-of-interrupt port clears remote IRR on every level entry whose vector equals v. Entries with other vectors keep the flag. A level entry whose line is still active requests again straight after that write.
- R8: Delivery status (bit 12) reads 1 while the entry has a request waiting that has not been accepted, and reads 0 once it has been accepted.
- R9: Software writes to bit 12 and bit 14 of a low word are ignored.
- R10: When several entries request at once, the lowest line number wins. `req_vector`, `req_dest`, `req_mode` and `req_logical` carry that entry's vector, destination ID, delivery mode and destination mode.
- R11: With polarity bit 13 set, a line held low counts as active and a line held high counts as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the target chosen by bus_sel |
| bus_sel | input | 2 | 0 index, 1 data window, 2 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the chosen target (combinational) |
| irq_in | input | NUM_LINES | External interrupt lines |
| req_valid | output | 1 | A delivery request is offered |
| req_ready | input | 1 | The local controller accepts the offered request |
| req_vector | output | 8 | Vector of the offered request |
| req_dest | output | 8 | Destination ID of the offered request |
| req_mode | output | 3 | Delivery mode of the offered request |
| req_logical | output | 1 | Destination mode of the offered request |

## Verification
Each result has its own latency, and the bench samples it exactly then:
- Table and index writes take effect on the clock edge that follows the write strobe. The bench reads them back combinationally half a cycle later.
- A line first passes through one input register. A level entry's request therefore appears after one edge.
- An edge entry needs a second edge to record the event. The bench checks that this request is still low after one edge and high after two.
- An acceptance or an end-of-interrupt write acts on the edge where `req_ready` or the write strobe is high. The bench changes stimulus on falling edges and checks the outputs before the next rising edge.

// File: rtl/irt_pkg.sv
package irt_pkg;

   localparam int VEC_W  = 8;
   localparam int DEST_W = 8;

   typedef enum logic [1:0] {
      BUS_INDEX  = 2'd0,
      BUS_WINDOW = 2'd1,
      BUS_EOI    = 2'd2
   } bus_sel_e;

   // programmable part of a low word
   typedef struct packed {
      logic             mask;
      logic             level;
      logic             act_low;
      logic             logical;
      logic [2:0]       mode;
      logic [VEC_W-1:0] vector;
   } rte_cfg_t;

   localparam rte_cfg_t CFG_RESET = '{mask: 1'b1, level: 1'b0, act_low: 1'b0,
                                      logical: 1'b0, mode: 3'd0, vector: '0};

   function automatic logic [31:0] pack_lo(rte_cfg_t c, logic rirr, logic busy);
      return {15'd0, c.mask, c.level, rirr, c.act_low, busy, c.logical, c.mode, c.vector};
   endfunction

   function automatic rte_cfg_t unpack_lo(logic [31:0] w);
      rte_cfg_t c;
      c.vector  = w[7:0];
      c.mode    = w[10:8];
      c.logical = w[11];
      c.act_low = w[13];
      c.level   = w[15];
      c.mask    = w[16];
      return c;
   endfunction

endpackage

// File: rtl/irt_prio_arb.sv
module irt_prio_arb #(
   parameter int WIDTH = 8,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] req,
   output logic [WIDTH-1:0] grant,
   output logic [IDX_W-1:0] grant_idx,
   output logic             any
);

   assign any = |req;

   generate
      if (WIDTH == 1) begin : g_single
         assign grant     = req;
         assign grant_idx = '0;
      end else begin : g_chain
         always_comb begin
            grant     = '0;
            grant_idx = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (req[i]) begin
                  grant     = '0;
                  grant[i]  = 1'b1;
                  grant_idx = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irt_entry.sv
module irt_entry
   import irt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                irq_raw,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [31:0]         wdata,
   input  logic                eoi_wr,
   input  logic [VEC_W-1:0]    eoi_vec,
   input  logic                accept,
   output logic [31:0]         lo_word,
   output logic [31:0]         hi_word,
   output logic                req,
   output rte_cfg_t            cfg,
   output logic [DEST_W-1:0]   dest
);

   logic irq_q, act_d, edge_pend, rirr;
   logic act, edge_hit, lvl_req, eoi_hit;

   assign act      = irq_q ^ cfg.act_low;
   assign edge_hit = act & ~act_d;
   assign lvl_req  = cfg.level & act & ~cfg.mask & ~rirr;
   assign req      = (edge_pend & ~cfg.mask & ~cfg.level) | lvl_req;
   assign eoi_hit  = eoi_wr && (eoi_vec == cfg.vector);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= CFG_RESET;
         dest <= '0;
      end else begin
         if (wr_lo) cfg  <= unpack_lo(wdata);
         if (wr_hi) dest <= wdata[31:24];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         act_d <= 1'b0;
      end else begin
         irq_q <= irq_raw;
         act_d <= act;
      end
   end

   // edge event held until delivered
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    edge_pend <= 1'b0;
      else if (cfg.mask | cfg.level) edge_pend <= 1'b0;
      else if (edge_hit)             edge_pend <= 1'b1;
      else if (accept)               edge_pend <= 1'b0;
   end

   // remote IRR: set on accepted level request, cleared by matching EOI
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rirr <= 1'b0;
      else if (!cfg.level)         rirr <= 1'b0;
      else if (accept)             rirr <= 1'b1;
      else if (eoi_hit)            rirr <= 1'b0;
   end

   assign lo_word = pack_lo(cfg, rirr, req);
   assign hi_word = {dest, 24'd0};

   assert_accept_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !cfg.mask);
   assert_rirr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cfg.level) |=> rirr);
   assert_level_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rirr && cfg.level) |-> !req);
   assert_eoi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !accept) |=> !rirr);
   assert_rirr_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !accept && !eoi_hit) |=> (rirr == $past(rirr)));

endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
   import irt_pkg::*;
#(
   parameter int NUM_LINES  = 8,
   parameter int TBL_BASE   = 16,
   parameter int VER_INDEX  = 1,
   parameter int VERSION_ID = 32,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int TBL_END   = TBL_BASE + 2 * NUM_LINES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [1:0]            bus_sel,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_LINES-1:0]  irq_in,
   output logic                  req_valid,
   input  logic                  req_ready,
   output logic [VEC_W-1:0]      req_vector,
   output logic [DEST_W-1:0]     req_dest,
   output logic [2:0]            req_mode,
   output logic                  req_logical
);

   initial begin
      assert (NUM_LINES >= 1 && NUM_LINES <= 120)
         else $error("NUM_LINES out of range");
      assert (TBL_BASE >= 0 && TBL_END <= 256)
         else $error("table does not fit the 8-bit index space");
      assert (VER_INDEX < TBL_BASE || VER_INDEX >= TBL_END)
         else $error("version index overlaps the table");
   end

   logic [7:0]  idx_q;
   logic        wr_index, wr_window, eoi_wr, tbl_hit, hi_sel;
   logic [7:0]  tbl_off;
   logic [6:0]  ent_sel;
   logic [31:0] win_rdata, version_word;

   logic [NUM_LINES-1:0] line_req, grant, accept;
   logic [IDX_W-1:0]     gidx;
   logic [31:0]          lo_arr   [NUM_LINES];
   logic [31:0]          hi_arr   [NUM_LINES];
   rte_cfg_t             cfg_arr  [NUM_LINES];
   logic [DEST_W-1:0]    dest_arr [NUM_LINES];

   assign wr_index  = bus_wr && (bus_sel == BUS_INDEX);
   assign wr_window = bus_wr && (bus_sel == BUS_WINDOW);
   assign eoi_wr    = bus_wr && (bus_sel == BUS_EOI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= '0;
      else if (wr_index) idx_q <= bus_wdata[7:0];
   end

   assign tbl_hit = (int'(idx_q) >= TBL_BASE) && (int'(idx_q) < TBL_END);
   assign tbl_off = idx_q - 8'(TBL_BASE);
   assign ent_sel = tbl_off[7:1];
   assign hi_sel  = tbl_off[0];

   assign version_word = {8'd0, 8'(NUM_LINES), 8'd0, 8'(VERSION_ID)};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
         logic sel_this;
         assign sel_this   = wr_window && tbl_hit && (ent_sel == 7'(gi));
         assign accept[gi] = grant[gi] && req_ready;

         irt_entry i_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_raw (irq_in[gi]),
            .wr_lo   (sel_this && !hi_sel),
            .wr_hi   (sel_this && hi_sel),
            .wdata   (bus_wdata),
            .eoi_wr  (eoi_wr),
            .eoi_vec (bus_wdata[VEC_W-1:0]),
            .accept  (accept[gi]),
            .lo_word (lo_arr[gi]),
            .hi_word (hi_arr[gi]),
            .req     (line_req[gi]),
            .cfg     (cfg_arr[gi]),
            .dest    (dest_arr[gi])
         );
      end
   endgenerate

   irt_prio_arb #(.WIDTH(NUM_LINES)) i_arb (
      .req       (line_req),
      .grant     (grant),
      .grant_idx (gidx),
      .any       (req_valid)
   );

   assign req_vector  = cfg_arr[gidx].vector;
   assign req_mode    = cfg_arr[gidx].mode;
   assign req_logical = cfg_arr[gidx].logical;
   assign req_dest    = dest_arr[gidx];

   always_comb begin
      win_rdata = '0;
      if (int'(idx_q) == VER_INDEX) win_rdata = version_word;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (tbl_hit && ent_sel == 7'(i))
            win_rdata = hi_sel ? hi_arr[i] : lo_arr[i];
      end
   end

   always_comb begin
      unique case (bus_sel)
         BUS_INDEX:  bus_rdata = {24'd0, idx_q};
         BUS_WINDOW: bus_rdata = win_rdata;
         default:    bus_rdata = '0;
      endcase
   end

   assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot(grant));
   assert_no_grant_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (grant == '0));
   assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_index |=> $stable(idx_q));

endmodule

// File: tb/test_irt_ctrl.sv
module test_irt_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int ROWS       = 5;

   // {index, write data, expected readback}
   localparam logic [71:0] TABLE [ROWS] = '{
      {8'h16, 32'h0000_5F41, 32'h0000_0F41},
      {8'h17, 32'hAB00_1234, 32'hAB00_0000},
      {8'h10, 32'hFFFF_FFFF, 32'h0001_AFFF},
      {8'h10, 32'h0001_0000, 32'h0001_0000},
      {8'h01, 32'h0000_0000, 32'h0008_0020}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_sel = 2'd0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_in = '0;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [7:0]    req_vector, req_dest;
   logic [2:0]    req_mode;
   logic          req_logical;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irt_ctrl #(.NUM_LINES(N)) i_irt_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
      .req_dest(req_dest), .req_mode(req_mode), .req_logical(req_logical)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_write(logic [7:0] idx, logic [31:0] d);
      bus_write(2'd0, {24'd0, idx});
      bus_write(2'd1, d);
   endtask

   task automatic reg_read(logic [7:0] idx, output logic [31:0] d);
      bus_write(2'd0, {24'd0, idx});
      bus_sel = 2'd1;
      #1 d = bus_rdata;
   endtask

   task automatic accept_one();
      @(negedge clk); req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
   endtask

   task automatic edges(int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      check("R2 reset no request", {31'd0, req_valid}, 32'd0);
      reg_read(8'h10, rd); check("R2 reset low word line0", rd, 32'h0001_0000);
      reg_read(8'h1E, rd); check("R2 reset low word line7", rd, 32'h0001_0000);
      reg_read(8'h1F, rd); check("R2 reset high word line7", rd, 32'h0);
      reg_read(8'h01, rd); check("R3 version", rd, 32'h0008_0020);
      bus_sel = 2'd0; #1 check("R1 index readback", bus_rdata, 32'h01);
      reg_read(8'h40, rd); check("R1 unused index", rd, 32'h0);

      // table-driven window accesses
      for (int r = 0; r < ROWS; r++) begin
         reg_write(TABLE[r][71:64], TABLE[r][63:32]);
         reg_read(TABLE[r][71:64], rd);
         check($sformatf("R2 R9 R3 table row %0d", r), rd, TABLE[r][31:0]);
      end

      // R4: masked line 1 stays silent
      irq_in[1] = 1'b1;
      edges(3);
      check("R4 masked line", {31'd0, req_valid}, 32'd0);
      irq_in[1] = 1'b0;

      // R5: edge entry line3, vector 0x41, dest 0xAB, mode 7, logical
      @(negedge clk); irq_in[3] = 1'b1;
      edges(1);
      check("R5 edge after one edge", {31'd0, req_valid}, 32'd0);
      edges(1);
      check("R5 edge after two edges", {31'd0, req_valid}, 32'd1);
      check("R10 vector", {24'd0, req_vector}, 32'h41);
      check("R10 dest", {24'd0, req_dest}, 32'hAB);
      check("R10 mode", {28'd0, req_logical, req_mode}, 32'hF);
      reg_read(8'h16, rd); check("R8 status while waiting", rd, 32'h0000_1F41);
      accept_one();
      check("R5 withdrawn after accept", {31'd0, req_valid}, 32'd0);
      edges(3);
      check("R5 no repeat while high", {31'd0, req_valid}, 32'd0);
      reg_read(8'h16, rd); check("R8 status cleared", rd, 32'h0000_0F41);
      irq_in[3] = 1'b0;

      // R11/R6: level entry line5 active low, vector 0x65
      irq_in[5] = 1'b1;
      reg_write(8'h1A, 32'h0000_A065);
      edges(2);
      check("R11 high is inactive", {31'd0, req_valid}, 32'd0);
      irq_in[5] = 1'b0;
      edges(1);
      check("R11 R6 low is active", {31'd0, req_valid}, 32'd1);
      check("R6 vector", {24'd0, req_vector}, 32'h65);
      accept_one();
      check("R6 held off by remote IRR", {31'd0, req_valid}, 32'd0);
      reg_read(8'h1A, rd); check("R6 remote IRR set", rd, 32'h0000_E065);

      // R9: rewrite with bit14 clear must not clear remote IRR
      reg_write(8'h1A, 32'h0000_A065);
      reg_read(8'h1A, rd); check("R9 remote IRR read-only", rd, 32'h0000_E065);
      check("R9 still quiet", {31'd0, req_valid}, 32'd0);

      // R7: EOI
      bus_write(2'd2, 32'h66);
      check("R7 wrong vector keeps IRR", {31'd0, req_valid}, 32'd0);
      reg_read(8'h1A, rd); check("R7 wrong vector IRR", rd, 32'h0000_E065);
      bus_write(2'd2, 32'h65);
      check("R7 redelivered after EOI", {31'd0, req_valid}, 32'd1);
      check("R7 vector", {24'd0, req_vector}, 32'h65);
      irq_in[5] = 1'b1;
      edges(2);
      check("R7 line released", {31'd0, req_valid}, 32'd0);

      // R10: priority, lines 3 and 6
      reg_write(8'h1C, 32'h0000_0070);
      reg_write(8'h1D, 32'h5500_0000);
      @(negedge clk); irq_in[3] = 1'b1; irq_in[6] = 1'b1;
      edges(2);
      check("R10 lowest first vec", {24'd0, req_vector}, 32'h41);
      check("R10 lowest first dest", {24'd0, req_dest}, 32'hAB);
      accept_one();
      check("R10 second valid", {31'd0, req_valid}, 32'd1);
      check("R10 second vec", {24'd0, req_vector}, 32'h70);
      check("R10 second dest", {24'd0, req_dest}, 32'h55);
      accept_one();
      check("R10 all served", {31'd0, req_valid}, 32'd0);

      // R4: masking a waiting edge request withdraws it
      irq_in[6] = 1'b0;
      edges(1);
      @(negedge clk); irq_in[6] = 1'b1;
      edges(2);
      check("R5 new edge pending", {31'd0, req_valid}, 32'd1);
      reg_write(8'h1C, 32'h0001_0070);
      check("R4 mask withdraws", {31'd0, req_valid}, 32'd0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule